// File: doc/BRIEF.md
# CPU/GPU Power Bias Controller

This block splits one shared power budget between the processor cores and the graphics engine. At every sample strobe it tests whether the measured CPU/ring frequency falls short of a workload-derived target. The margin for this test is a guard band. A shortfall pushes the split toward the CPU. Any other result pushes it toward the GPU.

The CPU share is a whole-percent value from 0 to 100, and the GPU receives the remainder. Each strobe moves the share by a programmable step, and the result is clamped to a programmable window. The share never moves in the direction opposite to the last applied move until the new direction has been indicated on a programmable number of consecutive strobes. This hysteresis stops the split from oscillating when the frequency sits close to the threshold.

From the share and the total power limit, the block derives the CPU and GPU power limits.

Top module: `pwr_bias_ctrl`

## Requirements
- R1: While `rst` is high, the share loads the default `cfg_default`, clamped into the window. The window's upper bound is `min(cfg_share_max, 100)`. Its lower bound is `cfg_share_min`, but no higher than the upper bound.
- R2: A strobe sees a shortfall when `freq_act + guard_band < freq_tgt`, computed without overflow. When the held direction is toward the CPU, such a strobe raises the share by `cfg_step`.
- R3: A strobe that sees no shortfall indicates the GPU direction. This includes equality, and a target below the guard band. When the held direction is toward the GPU, such a strobe lowers the share by `cfg_step`, and the result never goes below zero.
- R4: Every move clamps the new share into the R1 window. The share never exceeds 100.
- R5: A strobe that indicates the direction opposite to the held one raises a streak count and leaves the share unchanged. Once the streak reaches `cfg_hyst`, that strobe flips the held direction and moves the share in the new direction. A strobe that agrees with the held direction clears the streak. A `cfg_hyst` of 0 or 1 reverses on the first opposite strobe.
- R6: In a cycle without a strobe, the share holds.
- R7: `cpu_limit` equals floor(`pwr_total` × share / 100). `gpu_limit` equals `pwr_total − cpu_limit`. Both follow the share and `pwr_total` with no added register delay.
- R8: After reset, the held direction is toward the CPU, and the streak is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample | input | 1 | One-cycle sample strobe |
| freq_act | input | FREQ_W | Measured CPU/ring frequency |
| freq_tgt | input | FREQ_W | Workload-derived target frequency |
| guard_band | input | FREQ_W | Margin subtracted from the target |
| pwr_total | input | PWR_W | Total shared power limit |
| cfg_share_min | input | 7 | Lowest allowed CPU share, percent |
| cfg_share_max | input | 7 | Highest allowed CPU share, percent |
| cfg_default | input | 7 | Share loaded during reset, percent |
| cfg_step | input | 7 | Share change per strobe, percent |
| cfg_hyst | input | HYST_W | Consecutive opposite strobes needed to reverse |
| cpu_share | output | 7 | Current CPU share, percent |
| cpu_limit | output | PWR_W | Derived CPU power limit |
| gpu_limit | output | PWR_W | Derived GPU power limit |

## Verification
The share is one register deep. A strobe presented in one cycle therefore shows its effect on `cpu_share` right after the next rising edge. The two limits are combinational from the share and `pwr_total`, so they settle in that same cycle. The reset value of the share is visible as soon as `rst` has been high across one edge. The bench drives inputs on the falling edge, holds `sample` for exactly one cycle, and compares all three outputs on the falling edge that follows. That instant is half a period after the edge that consumed the strobe.

// File: rtl/pwr_bias_pkg.sv
package pwr_bias_pkg;

    localparam int SHARE_W  = 7;
    localparam int FULL_PCT = 100;

    typedef logic [SHARE_W-1:0] pct_t;

    typedef enum logic {
        TOWARD_CPU = 1'b0,
        TOWARD_GPU = 1'b1
    } bias_dir_e;

    typedef struct packed {
        logic      move;
        bias_dir_e dir;
    } bias_move_t;

    // Clamp a widened candidate share into the legal window.
    function automatic pct_t pct_clamp(input logic [SHARE_W:0] val,
                                       input pct_t lo_in,
                                       input pct_t hi_in);
        pct_t hi;
        pct_t lo;
        hi = (hi_in > pct_t'(FULL_PCT)) ? pct_t'(FULL_PCT) : hi_in;
        lo = (lo_in > hi) ? hi : lo_in;
        if (val > {1'b0, hi})
            return hi;
        else if (val < {1'b0, lo})
            return lo;
        else
            return val[SHARE_W-1:0];
    endfunction

endpackage

// File: rtl/bias_dir_filter.sv
module bias_dir_filter
    import pwr_bias_pkg::*;
#(
    parameter int FREQ_W = 12,
    parameter int HYST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic [FREQ_W-1:0] freq_act,
    input  logic [FREQ_W-1:0] freq_tgt,
    input  logic [FREQ_W-1:0] guard_band,
    input  logic [HYST_W-1:0] cfg_hyst,
    output bias_move_t        mv
);

    bias_dir_e         held_q;
    logic [HYST_W-1:0] streak_q;
    logic [FREQ_W:0]   floor_sum;
    logic              shortfall;
    bias_dir_e         want;
    logic [HYST_W:0]   streak_nxt;
    logic              flip_ok;

    assign floor_sum  = {1'b0, freq_act} + {1'b0, guard_band};
    assign shortfall  = floor_sum < {1'b0, freq_tgt};
    assign want       = shortfall ? TOWARD_CPU : TOWARD_GPU;
    assign streak_nxt = {1'b0, streak_q} + 1'b1;
    assign flip_ok    = streak_nxt >= {1'b0, cfg_hyst};

    always_comb begin
        mv.move = 1'b0;
        mv.dir  = held_q;
        if (sample) begin
            if (want == held_q) begin
                mv.move = 1'b1;
            end else if (flip_ok) begin
                mv.move = 1'b1;
                mv.dir  = want;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q   <= TOWARD_CPU;
            streak_q <= '0;
        end else if (sample) begin
            if (want == held_q) begin
                streak_q <= '0;
            end else if (flip_ok) begin
                held_q   <= want;
                streak_q <= '0;
            end else begin
                streak_q <= streak_nxt[HYST_W-1:0];
            end
        end
    end

endmodule

// File: rtl/bias_share_reg.sv
module bias_share_reg
    import pwr_bias_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bias_move_t mv,
    input  pct_t       cfg_share_min,
    input  pct_t       cfg_share_max,
    input  pct_t       cfg_default,
    input  pct_t       cfg_step,
    output pct_t       share
);

    logic [SHARE_W:0] up_val;
    logic [SHARE_W:0] dn_val;

    assign up_val = {1'b0, share} + {1'b0, cfg_step};
    assign dn_val = (share > cfg_step) ? {1'b0, share - cfg_step} : '0;

    always_ff @(posedge clk) begin
        if (rst)
            share <= pct_clamp({1'b0, cfg_default}, cfg_share_min, cfg_share_max);
        else if (mv.move)
            share <= pct_clamp((mv.dir == TOWARD_CPU) ? up_val : dn_val,
                               cfg_share_min, cfg_share_max);
    end

endmodule

// File: rtl/bias_limit_split.sv
module bias_limit_split
    import pwr_bias_pkg::*;
#(
    parameter int PWR_W = 16
) (
    input  pct_t             share,
    input  logic [PWR_W-1:0] pwr_total,
    output logic [PWR_W-1:0] cpu_limit,
    output logic [PWR_W-1:0] gpu_limit
);

    localparam int PROD_W = PWR_W + SHARE_W;

    logic [PROD_W-1:0] prod;

    assign prod      = PROD_W'(pwr_total) * PROD_W'(share);
    assign cpu_limit = PWR_W'(prod / PROD_W'(FULL_PCT));
    assign gpu_limit = pwr_total - cpu_limit;

endmodule

// File: rtl/pwr_bias_ctrl.sv
module pwr_bias_ctrl
    import pwr_bias_pkg::*;
#(
    parameter int FREQ_W = 12,
    parameter int PWR_W  = 16,
    parameter int HYST_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic [FREQ_W-1:0] freq_act,
    input  logic [FREQ_W-1:0] freq_tgt,
    input  logic [FREQ_W-1:0] guard_band,
    input  logic [PWR_W-1:0]  pwr_total,
    input  logic [6:0]        cfg_share_min,
    input  logic [6:0]        cfg_share_max,
    input  logic [6:0]        cfg_default,
    input  logic [6:0]        cfg_step,
    input  logic [HYST_W-1:0] cfg_hyst,
    output logic [6:0]        cpu_share,
    output logic [PWR_W-1:0]  cpu_limit,
    output logic [PWR_W-1:0]  gpu_limit
);

    bias_move_t mv;
    pct_t       share;

    bias_dir_filter #(.FREQ_W(FREQ_W), .HYST_W(HYST_W)) u_filter (
        .clk        (clk),
        .rst        (rst),
        .sample     (sample),
        .freq_act   (freq_act),
        .freq_tgt   (freq_tgt),
        .guard_band (guard_band),
        .cfg_hyst   (cfg_hyst),
        .mv         (mv)
    );

    bias_share_reg u_share (
        .clk           (clk),
        .rst           (rst),
        .mv            (mv),
        .cfg_share_min (cfg_share_min),
        .cfg_share_max (cfg_share_max),
        .cfg_default   (cfg_default),
        .cfg_step      (cfg_step),
        .share         (share)
    );

    bias_limit_split #(.PWR_W(PWR_W)) u_split (
        .share     (share),
        .pwr_total (pwr_total),
        .cpu_limit (cpu_limit),
        .gpu_limit (gpu_limit)
    );

    assign cpu_share = share;

endmodule

// File: rtl/pwr_bias_ctrl_chk.sv
module pwr_bias_ctrl_chk #(
    parameter int FREQ_W = 12,
    parameter int PWR_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              sample,
    input logic [FREQ_W-1:0] freq_act,
    input logic [FREQ_W-1:0] freq_tgt,
    input logic [FREQ_W-1:0] guard_band,
    input logic [PWR_W-1:0]  pwr_total,
    input logic [6:0]        cfg_share_min,
    input logic [6:0]        cfg_share_max,
    input logic [6:0]        cpu_share,
    input logic [PWR_W-1:0]  cpu_limit,
    input logic [PWR_W-1:0]  gpu_limit
);

    logic short_seen;
    logic in_window;

    assign short_seen = ({1'b0, freq_act} + {1'b0, guard_band}) < {1'b0, freq_tgt};
    assign in_window  = (cpu_share >= cfg_share_min) && (cpu_share <= cfg_share_max);

    assert_share_cap_R4: assert property (@(posedge clk) disable iff (rst)
        cpu_share <= 7'd100);

    assert_limit_sum_R7: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, cpu_limit} + {1'b0, gpu_limit}) == {1'b0, pwr_total});

    assert_cpu_within_total_R7: assert property (@(posedge clk) disable iff (rst)
        cpu_limit <= pwr_total);

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !sample |=> $stable(cpu_share));

    assert_short_no_drop_R2: assert property (@(posedge clk) disable iff (rst)
        (sample && short_seen && in_window) |=> cpu_share >= $past(cpu_share));

    assert_surplus_no_rise_R3: assert property (@(posedge clk) disable iff (rst)
        (sample && !short_seen && in_window) |=> cpu_share <= $past(cpu_share));

endmodule

bind pwr_bias_ctrl pwr_bias_ctrl_chk #(.FREQ_W(FREQ_W), .PWR_W(PWR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .sample        (sample),
    .freq_act      (freq_act),
    .freq_tgt      (freq_tgt),
    .guard_band    (guard_band),
    .pwr_total     (pwr_total),
    .cfg_share_min (cfg_share_min),
    .cfg_share_max (cfg_share_max),
    .cpu_share     (cpu_share),
    .cpu_limit     (cpu_limit),
    .gpu_limit     (gpu_limit)
);

// File: tb/pwr_bias_ctrl_test.sv
`timescale 1ns/1ps
module pwr_bias_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample = 1'b0;
    logic [11:0] freq_act = '0, freq_tgt = '0, guard_band = '0;
    logic [15:0] pwr_total = 16'd1000;
    logic [6:0]  cfg_share_min = 7'd10, cfg_share_max = 7'd90;
    logic [6:0]  cfg_default = 7'd50, cfg_step = 7'd5;
    logic [3:0]  cfg_hyst = 4'd3;
    logic [6:0]  cpu_share;
    logic [15:0] cpu_limit, gpu_limit;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pwr_bias_ctrl uut (
        .clk(clk), .rst(rst), .sample(sample),
        .freq_act(freq_act), .freq_tgt(freq_tgt), .guard_band(guard_band),
        .pwr_total(pwr_total),
        .cfg_share_min(cfg_share_min), .cfg_share_max(cfg_share_max),
        .cfg_default(cfg_default), .cfg_step(cfg_step), .cfg_hyst(cfg_hyst),
        .cpu_share(cpu_share), .cpu_limit(cpu_limit), .gpu_limit(gpu_limit)
    );

    typedef struct packed {
        int act; int tgt; int gb; int total; int share; int cpu;
    } vec_t;

    // min 10, max 90, default 50, step 5, streak length 3
    localparam vec_t VECS [0:21] = '{
        '{800, 1000, 50, 1000, 55, 550},   // R2 held CPU
        '{800, 1000, 50,  777, 60, 466},   // R2, R7 floor
        '{1000,1000,  0,  500, 60, 300},   // R3 equality, R5 streak 1
        '{1000,1000,  0,  500, 60, 300},   // R5 streak 2
        '{100,  200, 10, 1000, 65, 650},   // R5 streak cleared, R2
        '{950, 1000, 50, 1000, 65, 650},   // R5 streak 1
        '{900, 1000,100, 1000, 65, 650},   // R5 streak 2
        '{0,     20, 30, 1234, 60, 740},   // R3 tgt<guard, R5 flip
        '{1000,1000,  0, 1000, 55, 550},
        '{1000,1000,  0, 1000, 50, 500},
        '{1000,1000,  0, 1000, 45, 450},
        '{1000,1000,  0, 1000, 40, 400},
        '{1000,1000,  0, 1000, 35, 350},
        '{1000,1000,  0, 1000, 30, 300},
        '{1000,1000,  0, 1000, 25, 250},
        '{1000,1000,  0, 1000, 20, 200},
        '{1000,1000,  0, 1000, 15, 150},
        '{1000,1000,  0, 1000, 10, 100},   // R4 reaches min
        '{1000,1000,  0, 1000, 10, 100},   // R4 clamp at min
        '{800, 1000, 50, 1000, 10, 100},   // R5 streak 1
        '{800, 1000, 50, 1000, 10, 100},   // R5 streak 2
        '{800, 1000, 50, 1000, 15, 150}    // R5 flip to CPU
    };

    task automatic check(input string tag, input int actual, input int expected);
        n_run++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic check_all(input string tag, input int sh, input int tot);
        int cpu_exp;
        cpu_exp = (tot * sh) / 100;
        check({tag, " share"}, int'(cpu_share), sh);
        check({tag, " cpu_limit R7"}, int'(cpu_limit), cpu_exp);
        check({tag, " gpu_limit R7"}, int'(gpu_limit), tot - cpu_exp);
    endtask

    task automatic do_reset(input int mn, input int mx, input int df,
                            input int st, input int hy);
        @(negedge clk);
        rst = 1'b1;
        sample = 1'b0;
        cfg_share_min = 7'(mn); cfg_share_max = 7'(mx);
        cfg_default = 7'(df); cfg_step = 7'(st); cfg_hyst = 4'(hy);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic strobe(input int act, input int tgt, input int gb, input int tot);
        @(negedge clk);
        freq_act = 12'(act); freq_tgt = 12'(tgt); guard_band = 12'(gb);
        pwr_total = 16'(tot);
        sample = 1'b1;
        @(negedge clk);
        sample = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset(10, 90, 50, 5, 3);
        check_all("R1 reset default", 50, 1000);

        // table walk: R2 R3 R4 R5 R7 R8
        for (int i = 0; i < 22; i++) begin
            strobe(VECS[i].act, VECS[i].tgt, VECS[i].gb, VECS[i].total);
            check_all($sformatf("vector %0d R2/R3/R5", i), VECS[i].share, VECS[i].total);
            check($sformatf("vector %0d table cpu R7", i), int'(cpu_limit), VECS[i].cpu);
        end

        // R6: no strobe, shortfall present
        @(negedge clk);
        freq_act = 12'd100; freq_tgt = 12'd900; guard_band = 12'd0;
        repeat (5) @(negedge clk);
        check_all("R6 idle hold", 15, 1000);

        // R1 default above max, R4 clamp at max
        do_reset(10, 90, 95, 10, 3);
        check_all("R1 default clamped to max", 90, 1000);
        strobe(100, 900, 0, 1000);
        check_all("R4 clamp at max", 90, 1000);

        // R1 default below min
        do_reset(10, 90, 3, 5, 3);
        check_all("R1 default clamped to min", 10, 1000);

        // R4 max above 100 caps at 100
        do_reset(0, 120, 100, 5, 1);
        check_all("R4 cap 100 reset", 100, 1000);
        strobe(100, 900, 0, 1000);
        check_all("R4 cap 100 after rise", 100, 1000);
        // R5 streak length 1 reverses at once
        strobe(900, 900, 0, 1000);
        check_all("R5 length 1 reversal", 95, 1000);

        // R5 streak length 0 reverses at once
        do_reset(0, 100, 50, 5, 0);
        strobe(900, 900, 0, 1000);
        check_all("R5 length 0 reversal", 45, 1000);

        // R8 initial direction CPU; R5 broken streak
        do_reset(0, 100, 50, 5, 2);
        strobe(100, 900, 0, 1000);
        check_all("R8 initial toward CPU", 55, 1000);
        strobe(900, 900, 0, 1000);
        check_all("R5 streak 1 holds", 55, 1000);
        strobe(100, 900, 0, 1000);
        check_all("R5 agree clears streak", 60, 1000);
        strobe(900, 900, 0, 1000);
        check_all("R5 restart streak holds", 60, 1000);
        strobe(900, 900, 0, 1000);
        check_all("R5 flip after 2", 55, 1000);

        // R3 step larger than share floors at zero
        do_reset(0, 100, 3, 5, 1);
        strobe(900, 900, 0, 1000);
        check_all("R3 floor at zero", 0, 1000);

        // R7 wide total
        do_reset(0, 100, 99, 1, 3);
        @(negedge clk);
        pwr_total = 16'd65535;
        @(negedge clk);
        check_all("R7 wide total", 99, 65535);
        check("R7 wide cpu", int'(cpu_limit), 64879);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule